// File: doc/BRIEF.md
# Cache Way Predictor

This block keeps a small table of way guesses next to a set-associative cache that has 2^WAY_BITS ways. For every cache access it names the one way whose data array should be read. The cache can then read and move a single block instead of all the ways. The guess is only a hint. The cache's own tag compare still decides whether the access hits. When the compare shows that the hit was in a different way, the predictor flags a wrong guess. The cache then spends one more cycle re-reading the way that really holds the block.

The table is indexed by the set index with a few low tag bits appended. Two lines that share a set but differ in those tag bits can therefore keep separate guesses. An entry is rewritten in only two cases. The first is a wrong guess on a hit, when the entry takes the way that actually hit. The second is a fill into the set, when the entry takes the way that was just filled. After reset every entry guesses way 0.

Top module: `way_predictor`

## Requirements
- R1: After reset, every table entry predicts way 0 until it is first written.
- R2: Lookups are pipelined. `pred_valid` and `pred_way` answer a lookup (`lk_valid` high) in the following cycle. `pred_valid` is low in any cycle that follows a cycle without a lookup.
- R3: The table index is `{set, tag_low}`, with the set index in the upper bits. Entries that share a set but differ in `tag_low` are independent.
- R4: If `cmp_valid`, `cmp_hit` and `pred_valid` are all high and `cmp_way` differs from `pred_way`, then in the next cycle `mispredict` is 1 and `fix_way` equals that `cmp_way`. After a correct guess, `mispredict` is 0 in the next cycle.
- R5: A tag-compare miss (`cmp_valid` high, `cmp_hit` low) never raises `mispredict` and leaves the entry unchanged.
- R6: After a wrong guess, the entry holds the way that hit, so the next lookup of that index predicts that way.
- R7: A fill (`fill_valid` high) writes `fill_way` into entry `{fill_set, fill_tag}`.
- R8: When a fill and a wrong-guess retrain fall in the same cycle, the fill is written and the retrain is dropped. The `mispredict` flag is still raised.
- R9: A lookup made in the same cycle as a write to the same index returns the newly written way.
- R10: A compare result that arrives while `pred_valid` is low is ignored. It raises no `mispredict` and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_set | input | SET_BITS | Set index of the lookup |
| lk_tag | input | TAG_BITS | Low tag bits of the lookup |
| cmp_valid | input | 1 | Tag compare result present (in the cycle after the lookup) |
| cmp_hit | input | 1 | Tag compare found a hit |
| cmp_way | input | WAY_BITS | Way that hit |
| fill_valid | input | 1 | A block has been placed into a way |
| fill_set | input | SET_BITS | Set index of the fill |
| fill_tag | input | TAG_BITS | Low tag bits of the filled line |
| fill_way | input | WAY_BITS | Way that was filled |
| pred_valid | output | 1 | Prediction present |
| pred_way | output | WAY_BITS | Predicted way |
| mispredict | output | 1 | Last guess was wrong; a re-access is needed |
| fix_way | output | WAY_BITS | Way to read on the re-access |

## Verification
The prediction for a lookup driven in cycle t is due in cycle t+1. A compare result driven in that same cycle t+1 produces `mispredict` and `fix_way` in cycle t+2. The retrained or filled entry is visible to any lookup issued in the write cycle or later. The bench drives inputs on the falling edge. It samples each result on the falling edge that falls inside the cycle where that result is due, which is exactly one or two rising edges after the stimulus. A shadow table in the bench, updated according to R6, R7 and R8, provides the expected guess for every lookup.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_FILL = 2'd1,
    WR_FIX  = 2'd2
  } wr_src_e;
endpackage

// File: rtl/wp_index.sv
module wp_index #(
  parameter int SET_BITS = 6,
  parameter int TAG_BITS = 2,
  localparam int IDX_BITS = SET_BITS + TAG_BITS
) (
  input  logic [SET_BITS-1:0] set_i,
  input  logic [TAG_BITS-1:0] tag_i,
  output logic [IDX_BITS-1:0] idx_o
);
  // set in the upper bits, tag slice below it
  generate
    if (TAG_BITS > 0) begin : g_hashed
      assign idx_o = {set_i, tag_i};
    end else begin : g_plain
      assign idx_o = set_i;
    end
  endgenerate
endmodule

// File: rtl/wp_table.sv
module wp_table #(
  parameter int IDX_BITS = 8,
  parameter int WAY_BITS = 2,
  localparam int DEPTH = 1 << IDX_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [IDX_BITS-1:0] rd_idx,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [WAY_BITS-1:0] wr_way,
  output logic                rd_valid,
  output logic [IDX_BITS-1:0] rd_idx_q,
  output logic [WAY_BITS-1:0] rd_way
);
  // plain RAM with no reset, read-first, so it maps to block RAM
  logic [WAY_BITS-1:0] mem [DEPTH];
  logic [WAY_BITS-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_way;
    mem_q <= mem[rd_idx];
  end

  // per-entry written flags give the reset-to-way-0 behaviour
  logic [DEPTH-1:0]    written;
  logic                written_q;
  logic                byp_q;
  logic [WAY_BITS-1:0] byp_way_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
    end else if (wr_en) begin
      written[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_idx_q  <= '0;
      written_q <= 1'b0;
      byp_q     <= 1'b0;
      byp_way_q <= '0;
    end else begin
      rd_valid  <= rd_en;
      rd_idx_q  <= rd_idx;
      written_q <= written[rd_idx];
      byp_q     <= wr_en && (wr_idx == rd_idx);
      byp_way_q <= wr_way;
    end
  end

  always_comb begin
    if (byp_q)          rd_way = byp_way_q;
    else if (written_q) rd_way = mem_q;
    else                rd_way = '0;
  end

  // R9: same-cycle write is forwarded to the read
  p_forward_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && (rd_idx == wr_idx)) |=> (rd_way == $past(wr_way)));
endmodule

// File: rtl/wp_train.sv
module wp_train
  import wp_pkg::*;
#(
  parameter int IDX_BITS = 8,
  parameter int WAY_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pred_valid,
  input  logic [WAY_BITS-1:0] pred_way,
  input  logic [IDX_BITS-1:0] pred_idx,
  input  logic                cmp_valid,
  input  logic                cmp_hit,
  input  logic [WAY_BITS-1:0] cmp_way,
  input  logic                fill_valid,
  input  logic [IDX_BITS-1:0] fill_idx,
  input  logic [WAY_BITS-1:0] fill_way,
  output logic                wr_en,
  output logic [IDX_BITS-1:0] wr_idx,
  output logic [WAY_BITS-1:0] wr_way,
  output logic                mispredict,
  output logic [WAY_BITS-1:0] fix_way
);
  logic    wrong;
  wr_src_e src;

  assign wrong = pred_valid && cmp_valid && cmp_hit && (cmp_way != pred_way);

  always_comb begin
    if (fill_valid) src = WR_FILL;
    else if (wrong) src = WR_FIX;
    else            src = WR_NONE;
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = pred_idx;
    wr_way = cmp_way;
    unique case (src)
      WR_FILL: begin
        wr_en  = 1'b1;
        wr_idx = fill_idx;
        wr_way = fill_way;
      end
      WR_FIX:  wr_en = 1'b1;
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict <= 1'b0;
      fix_way    <= '0;
    end else begin
      mispredict <= wrong;
      fix_way    <= cmp_way;
    end
  end

  // R4: a flagged guess always names a way other than the one guessed
  p_fix_differs_r4: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> (fix_way != $past(pred_way)));
  // R5: a miss never flags a wrong guess
  p_miss_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_hit) |=> !mispredict);
  // R10: a compare with no prediction is ignored
  p_orphan_cmp_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !pred_valid && !fill_valid) |-> !wr_en);
  // R8: a fill takes the write port
  p_fill_first_r8: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (wr_en && (wr_idx == fill_idx) && (wr_way == fill_way)));
endmodule

// File: rtl/way_predictor.sv
module way_predictor #(
  parameter int WAY_BITS = 2,
  parameter int SET_BITS = 6,
  parameter int TAG_BITS = 2,
  localparam int IDX_BITS = SET_BITS + TAG_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_valid,
  input  logic [SET_BITS-1:0] lk_set,
  input  logic [TAG_BITS-1:0] lk_tag,
  input  logic                cmp_valid,
  input  logic                cmp_hit,
  input  logic [WAY_BITS-1:0] cmp_way,
  input  logic                fill_valid,
  input  logic [SET_BITS-1:0] fill_set,
  input  logic [TAG_BITS-1:0] fill_tag,
  input  logic [WAY_BITS-1:0] fill_way,
  output logic                pred_valid,
  output logic [WAY_BITS-1:0] pred_way,
  output logic                mispredict,
  output logic [WAY_BITS-1:0] fix_way
);
  logic [IDX_BITS-1:0] lk_idx, fill_idx, pred_idx, wr_idx;
  logic                wr_en;
  logic [WAY_BITS-1:0] wr_way;

  wp_index #(.SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS)) u_lk_index (
    .set_i(lk_set), .tag_i(lk_tag), .idx_o(lk_idx));

  wp_index #(.SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS)) u_fill_index (
    .set_i(fill_set), .tag_i(fill_tag), .idx_o(fill_idx));

  wp_table #(.IDX_BITS(IDX_BITS), .WAY_BITS(WAY_BITS)) u_table (
    .clk(clk), .rst(rst),
    .rd_en(lk_valid), .rd_idx(lk_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way),
    .rd_valid(pred_valid), .rd_idx_q(pred_idx), .rd_way(pred_way));

  wp_train #(.IDX_BITS(IDX_BITS), .WAY_BITS(WAY_BITS)) u_train (
    .clk(clk), .rst(rst),
    .pred_valid(pred_valid), .pred_way(pred_way), .pred_idx(pred_idx),
    .cmp_valid(cmp_valid), .cmp_hit(cmp_hit), .cmp_way(cmp_way),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way),
    .mispredict(mispredict), .fix_way(fix_way));

  // R2: a prediction only ever follows a lookup
  p_pred_timing_r2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(lk_valid));
  // R4: a wrong-guess flag only follows a hit compare
  p_flag_source_r4: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(cmp_valid && cmp_hit && pred_valid));
endmodule

// File: tb/way_predictor_bench.sv
module way_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 2;
  localparam int SB = 6;
  localparam int TB = 2;
  localparam int DEPTH = 1 << (SB + TB);

  logic clk = 1'b0;
  logic rst;
  logic lk_valid, cmp_valid, cmp_hit, fill_valid;
  logic [SB-1:0] lk_set, fill_set;
  logic [TB-1:0] lk_tag, fill_tag;
  logic [WB-1:0] cmp_way, fill_way;
  logic pred_valid, mispredict;
  logic [WB-1:0] pred_way, fix_way;

  int n_checks = 0;
  int n_fail = 0;
  logic [WB-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  way_predictor #(.WAY_BITS(WB), .SET_BITS(SB), .TAG_BITS(TB)) u_way_predictor (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag),
    .cmp_valid(cmp_valid), .cmp_hit(cmp_hit), .cmp_way(cmp_way),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_way(fill_way), .pred_valid(pred_valid), .pred_way(pred_way),
    .mispredict(mispredict), .fix_way(fix_way));

  function automatic int idx_of(input int s, input int t);
    return s * (1 << TB) + t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; cmp_valid = 0; cmp_hit = 0; fill_valid = 0;
  endtask

  // lookup + compare; checks prediction then mispredict
  task automatic access(input int s, input int t, input bit hit, input int w, input string req);
    int i;
    bit exp_mis;
    i = idx_of(s, t);
    @(negedge clk);
    idle_inputs();
    lk_valid = 1; lk_set = SB'(s); lk_tag = TB'(t);
    @(negedge clk);
    idle_inputs();
    check(pred_valid == 1'b1, "R2", int'(pred_valid), 1);
    check(pred_way == model[i], req, int'(pred_way), int'(model[i]));
    exp_mis = hit && (WB'(w) != model[i]);
    cmp_valid = 1; cmp_hit = hit; cmp_way = WB'(w);
    if (exp_mis) model[i] = WB'(w);
    @(negedge clk);
    idle_inputs();
    check(mispredict == exp_mis, "R4", int'(mispredict), int'(exp_mis));
    if (exp_mis) check(fix_way == WB'(w), "R4", int'(fix_way), w);
  endtask

  task automatic lookup_only(input int s, input int t, input string req);
    int i;
    i = idx_of(s, t);
    @(negedge clk);
    idle_inputs();
    lk_valid = 1; lk_set = SB'(s); lk_tag = TB'(t);
    @(negedge clk);
    idle_inputs();
    check(pred_way == model[i], req, int'(pred_way), int'(model[i]));
  endtask

  task automatic do_fill(input int s, input int t, input int w);
    @(negedge clk);
    idle_inputs();
    fill_valid = 1; fill_set = SB'(s); fill_tag = TB'(t); fill_way = WB'(w);
    model[idx_of(s, t)] = WB'(w);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    idle_inputs();
    lk_set = '0; lk_tag = '0; cmp_way = '0;
    fill_set = '0; fill_tag = '0; fill_way = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(pred_valid == 1'b0, "R2", int'(pred_valid), 0);
    check(mispredict == 1'b0, "R1", int'(mispredict), 0);

    // R1: untouched entries guess way 0
    lookup_only(0, 0, "R1");
    lookup_only(63, 3, "R1");
    lookup_only(17, 2, "R1");
    @(negedge clk);
    check(pred_valid == 1'b0, "R2", int'(pred_valid), 0);

    // R6: retrain then predict
    access(5, 1, 1, 3, "R6");
    access(5, 1, 1, 3, "R6");
    // R3: neighbour tag slice untouched
    lookup_only(5, 0, "R3");
    lookup_only(5, 2, "R3");
    // R5: miss leaves entry and flag alone
    access(5, 1, 0, 1, "R5");
    lookup_only(5, 1, "R5");
    // R7: fill writes entry
    do_fill(9, 2, 2);
    lookup_only(9, 2, "R7");

    // R10: compare with no prediction outstanding
    @(negedge clk);
    idle_inputs();
    cmp_valid = 1; cmp_hit = 1; cmp_way = 2'd1;
    @(negedge clk);
    idle_inputs();
    check(mispredict == 1'b0, "R10", int'(mispredict), 0);
    lookup_only(5, 1, "R10");

    // R8: fill and retrain collide; fill wins, flag still raised
    @(negedge clk);
    idle_inputs();
    lk_valid = 1; lk_set = 6'd12; lk_tag = 2'd0;
    @(negedge clk);
    idle_inputs();
    check(pred_way == model[idx_of(12, 0)], "R8", int'(pred_way), int'(model[idx_of(12, 0)]));
    cmp_valid = 1; cmp_hit = 1; cmp_way = 2'd2;
    fill_valid = 1; fill_set = 6'd13; fill_tag = 2'd1; fill_way = 2'd3;
    model[idx_of(13, 1)] = 2'd3;
    @(negedge clk);
    idle_inputs();
    check(mispredict == 1'b1, "R8", int'(mispredict), 1);
    lookup_only(12, 0, "R8");
    lookup_only(13, 1, "R8");

    // R9: lookup in the same cycle as a fill to the same index
    @(negedge clk);
    idle_inputs();
    lk_valid = 1; lk_set = 6'd20; lk_tag = 2'd3;
    fill_valid = 1; fill_set = 6'd20; fill_tag = 2'd3; fill_way = 2'd2;
    model[idx_of(20, 3)] = 2'd2;
    @(negedge clk);
    idle_inputs();
    check(pred_way == 2'd2, "R9", int'(pred_way), 2);

    // random mix on a few sets to force reuse
    for (int n = 0; n < 500; n++) begin
      int s, t, w;
      s = int'($urandom % 4);
      t = int'($urandom % 4);
      w = int'($urandom % 4);
      if ($urandom % 5 == 0) do_fill(s, t, w);
      else access(s, t, ($urandom % 5) != 0, w, "R6");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule